// File: doc/BRIEF.md
# Serial Control Port for a Frequency Synthesizer

This block is the slave side of the serial control link of a digital frequency synthesizer. A host selects the port with an active-low chip select and clocks transactions over a serial clock and one bidirectional data pin. Each transaction opens with an instruction byte that names a register and says whether it is read or written. A data phase then moves as many bytes as that register holds, most significant byte first.

Writes never act on the synthesizer directly. They fill a shadow (buffer) register set one whole byte at a time. A separate update input is brought into the system clock domain and edge-detected. Each detected rising edge copies the whole buffer set into the active set, which drives the frequency, phase and amplitude outputs.

A port-reset input abandons the current transaction at any time. After it is released the port expects a fresh instruction byte. All serial inputs are oversampled by the system clock, so the serial clock must run well below the system clock rate.

Top module: `synth_serial_ctrl`

## Requirements
- R1: The first 8 serial-clock rising edges of a transaction carry the instruction byte, MSB first. Bit 7 set means read, clear means write. Bits 3:0 are the register address, and bits 6:4 are ignored.
- R2: Register map by address: 0 is the 48-bit frequency word (6 data bytes), 1 is the 14-bit phase word (2 bytes), 2 is the 12-bit amplitude word (2 bytes). Any other address takes 1 data byte; a write to it is discarded and a read of it returns 0x00. Data bytes are MSB first, and bits above a register's width are dropped.
- R3: Write data is sampled on serial-clock rising edges and lands in the buffer register; the active outputs do not change until an update edge.
- R4: A rising edge on the update input, after synchronization, copies every buffer register to the active outputs. A level held high causes only one copy.
- R5: A read drives the buffer contents on the data pin, MSB first. The first bit goes out on the falling edge after the instruction byte and each later bit on the next falling edge. The pin is released once the data phase ends.
- R6: After the last data byte, the next 8 rising edges form a new instruction byte without chip select being raised.
- R7: A high port reset ends the transaction at once and discards a partially received byte. Bytes already received stay in the buffer. After the release, the next 8 rising edges form an instruction byte.
- R8: While chip select is high, the serial clock is ignored, the data pin is released, and any transaction in progress is abandoned.
- R9: An update edge that arrives in the middle of a write copies only the bytes fully received before it.
- R10: After system reset all buffer and active registers are zero and the data pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdio | inout | 1 | Bidirectional serial data |
| io_rst | input | 1 | Port reset, high aborts the transaction |
| upd | input | 1 | Asynchronous update strobe |
| freq_word | output | 48 | Active frequency word |
| phase_word | output | 14 | Active phase word |
| amp_word | output | 12 | Active amplitude word |

## Verification
The checker holds on every cycle that the active outputs stay put in any cycle not preceded by a detected update edge, and that a raised chip select releases the data pin. It also confirms that a port reset leaves the engine waiting for a new instruction, and that a data phase only opens on the rising edge that completes an 8-bit instruction. Byte ordering and register sizes are shown only by the bench's scenarios. So are back-to-back transactions, dropping of a partial byte on port reset, partial transfer on a mid-write update, and the tri-state release of a live read.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int FREQ_W  = 48;
  localparam int PHASE_W = 14;
  localparam int AMP_W   = 12;
  localparam int NREGS   = 3;
  localparam int ADDR_W  = 4;
  localparam int MAX_W   = 48;
  localparam int MAX_B   = (MAX_W + 7) / 8;
  localparam int BIDX_W  = $clog2(MAX_B + 1);
  localparam int SEL_W   = $clog2(NREGS);

  localparam logic [ADDR_W-1:0] ADR_FREQ  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_PHASE = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_AMP   = 4'd2;

  typedef enum logic {PH_INSTR, PH_DATA} phase_e;

  function automatic int reg_width(input int idx);
    case (idx)
      0:       return FREQ_W;
      1:       return PHASE_W;
      2:       return AMP_W;
      default: return 8;
    endcase
  endfunction

  function automatic logic [BIDX_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a);
    if (int'(a) < NREGS) return BIDX_W'((reg_width(int'(a)) + 7) / 8);
    else                 return BIDX_W'(1);
  endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= (chain << 1) | STAGES'(d);
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/sctl_engine.sv
module sctl_engine
  import synth_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              iorst_s,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              din,
  input  logic [MAX_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BIDX_W-1:0] wr_pos,
  output logic [7:0]        wr_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              in_data,
  output logic [2:0]        bit_cnt_o
);
  phase_e            ph;
  logic [2:0]        bit_cnt;
  logic [BIDX_W-1:0] byte_cnt;
  logic [BIDX_W-1:0] cur_nb;
  logic [7:0]        sr;
  logic              cur_rd;
  logic [ADDR_W-1:0] cur_addr;
  logic [MAX_W-1:0]  rd_sr;

  logic              active;
  logic [7:0]        sr_nxt;
  logic [BIDX_W-1:0] nb_nxt;
  logic [MAX_W-1:0]  rd_aligned;

  assign active  = !cs_s && !iorst_s;
  assign sr_nxt  = {sr[6:0], din};
  assign rd_addr = sr_nxt[ADDR_W-1:0];
  assign nb_nxt  = reg_bytes(sr_nxt[ADDR_W-1:0]);

  // Left-align the addressed buffer so its top data byte leaves first.
  always_comb begin
    rd_aligned = rd_data << ((MAX_B - int'(nb_nxt)) * 8);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_INSTR;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      cur_nb   <= '0;
      sr       <= '0;
      cur_rd   <= 1'b0;
      cur_addr <= '0;
      rd_sr    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_pos   <= '0;
      wr_data  <= '0;
      sdo      <= 1'b0;
      sdo_oe   <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (!active) begin
        ph       <= PH_INSTR;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        sdo_oe   <= 1'b0;
      end else begin
        if (sck_rise) begin
          sr      <= sr_nxt;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (ph == PH_INSTR) begin
              ph       <= PH_DATA;
              byte_cnt <= '0;
              cur_rd   <= sr_nxt[7];
              cur_addr <= sr_nxt[ADDR_W-1:0];
              cur_nb   <= nb_nxt;
              rd_sr    <= rd_aligned;
            end else begin
              if (!cur_rd && int'(cur_addr) < NREGS) begin
                wr_en   <= 1'b1;
                wr_addr <= cur_addr;
                wr_pos  <= cur_nb - BIDX_W'(1) - byte_cnt;
                wr_data <= sr_nxt;
              end
              byte_cnt <= byte_cnt + BIDX_W'(1);
              if (byte_cnt == cur_nb - BIDX_W'(1)) ph <= PH_INSTR;
            end
          end
        end
        if (ph == PH_DATA && cur_rd && sck_fall) begin
          sdo    <= rd_sr[MAX_W-1];
          rd_sr  <= rd_sr << 1;
          sdo_oe <= 1'b1;
        end else if (ph == PH_INSTR) begin
          sdo_oe <= 1'b0;
        end
      end
    end
  end

  assign in_data   = (ph == PH_DATA);
  assign bit_cnt_o = bit_cnt;
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
  import synth_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BIDX_W-1:0]  wr_pos,
  input  logic [7:0]         wr_data,
  input  logic               upd_pulse,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [MAX_W-1:0]   rd_data,
  output logic [FREQ_W-1:0]  freq_word,
  output logic [PHASE_W-1:0] phase_word,
  output logic [AMP_W-1:0]   amp_word
);
  logic [NREGS-1:0][MAX_W-1:0] buf_all;
  logic [NREGS-1:0][MAX_W-1:0] act_all;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam logic [MAX_W-1:0] MASK = MAX_W'((64'd1 << reg_width(g)) - 64'd1);
    logic [MAX_W-1:0] buf_r;
    logic [MAX_W-1:0] act_r;
    logic [MAX_W-1:0] merged;

    always_comb begin
      merged = buf_r;
      merged[{wr_pos, 3'b000} +: 8] = wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        buf_r <= '0;
        act_r <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(g)) buf_r <= merged & MASK;
        if (upd_pulse) act_r <= buf_r;
      end
    end

    assign buf_all[g] = buf_r;
    assign act_all[g] = act_r;
  end

  always_comb begin
    if (int'(rd_addr) < NREGS) rd_data = buf_all[rd_addr[SEL_W-1:0]];
    else                       rd_data = '0;
  end

  assign freq_word  = act_all[ADR_FREQ[SEL_W-1:0]][FREQ_W-1:0];
  assign phase_word = act_all[ADR_PHASE[SEL_W-1:0]][PHASE_W-1:0];
  assign amp_word   = act_all[ADR_AMP[SEL_W-1:0]][AMP_W-1:0];
endmodule

// File: rtl/synth_serial_ctrl.sv
module synth_serial_ctrl
  import synth_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               sclk,
  inout  wire                sdio,
  input  logic               io_rst,
  input  logic               upd,
  output logic [FREQ_W-1:0]  freq_word,
  output logic [PHASE_W-1:0] phase_word,
  output logic [AMP_W-1:0]   amp_word
);
  localparam int NIN = 5;
  localparam int I_DIN = 0, I_SCK = 1, I_CS = 2, I_IOR = 3, I_UPD = 4;

  logic [NIN-1:0] raw, syn, syn_rise, syn_fall;

  assign raw = {upd, io_rst, cs_n, sclk, sdio};

  for (genvar i = 0; i < NIN; i++) begin : g_sync
    sctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .d    (raw[i]),
      .q    (syn[i]),
      .rise (syn_rise[i]),
      .fall (syn_fall[i])
    );
  end

  logic              cs_s, iorst_s, upd_pulse, sck_rise, sck_fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [MAX_W-1:0]  rd_data;
  logic              wr_en, sdo, sdo_oe, in_data;
  logic [BIDX_W-1:0] wr_pos;
  logic [7:0]        wr_data;
  logic [2:0]        bit_cnt;

  assign cs_s      = syn[I_CS];
  assign iorst_s   = syn[I_IOR];
  assign upd_pulse = syn_rise[I_UPD];
  assign sck_rise  = syn_rise[I_SCK];
  assign sck_fall  = syn_fall[I_SCK];

  sctl_engine u_eng (
    .clk       (clk),
    .rst       (rst),
    .cs_s      (cs_s),
    .iorst_s   (iorst_s),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .din       (syn[I_DIN]),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_pos    (wr_pos),
    .wr_data   (wr_data),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .in_data   (in_data),
    .bit_cnt_o (bit_cnt)
  );

  sctl_regbank u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_pos     (wr_pos),
    .wr_data    (wr_data),
    .upd_pulse  (upd_pulse),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .freq_word  (freq_word),
    .phase_word (phase_word),
    .amp_word   (amp_word)
  );

  assign sdio = sdo_oe ? sdo : 1'bz;
endmodule

// File: rtl/synth_serial_ctrl_chk.sv
module synth_serial_ctrl_chk
  import synth_ctrl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               cs_s,
  input logic               iorst_s,
  input logic               upd_pulse,
  input logic               sck_rise,
  input logic               in_data,
  input logic [2:0]         bit_cnt,
  input logic               sdo_oe,
  input logic               wr_en,
  input logic [FREQ_W-1:0]  freq_word,
  input logic [PHASE_W-1:0] phase_word,
  input logic [AMP_W-1:0]   amp_word
);
  // R3: active words only move right after a detected update edge
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !upd_pulse |=> ($stable(freq_word) && $stable(phase_word) && $stable(amp_word)));

  // R8: chip select high releases the data pin
  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sdo_oe);

  // R8: no buffer write is issued unless the port was selected
  assert_selected_write_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(!cs_s));

  // R7: port reset returns the engine to an empty instruction phase
  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    iorst_s |=> (!in_data && bit_cnt == 3'd0));

  // R1: a data phase opens only on the rise completing 8 instruction bits
  assert_instr_len_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(in_data) |-> ($past(sck_rise) && $past(bit_cnt) == 3'd7));

  // R5: the pin is never driven while a write byte is being stored
  assert_no_drive_on_write_R5: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && sdo_oe));
endmodule

bind synth_serial_ctrl synth_serial_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_s       (cs_s),
  .iorst_s    (iorst_s),
  .upd_pulse  (upd_pulse),
  .sck_rise   (sck_rise),
  .in_data    (in_data),
  .bit_cnt    (bit_cnt),
  .sdo_oe     (sdo_oe),
  .wr_en      (wr_en),
  .freq_word  (freq_word),
  .phase_word (phase_word),
  .amp_word   (amp_word)
);

// File: tb/synth_serial_ctrl_test.sv
`timescale 1ns/1ps
module synth_serial_ctrl_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic io_rst = 1'b0;
  logic upd = 1'b0;
  logic tb_oe = 1'b1;
  logic tb_bit = 1'b0;
  wire  sdio;
  logic [47:0] freq_word;
  logic [13:0] phase_word;
  logic [11:0] amp_word;

  assign sdio = tb_oe ? tb_bit : 1'bz;

  always #10 clk = ~clk;

  synth_serial_ctrl uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio(sdio),
    .io_rst(io_rst), .upd(upd),
    .freq_word(freq_word), .phase_word(phase_word), .amp_word(amp_word)
  );

  typedef struct {
    string       req;
    logic [47:0] val;
  } exp_t;

  exp_t        exp_q[$];
  event        obs_ev;
  logic [47:0] obs_val;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model of buffer and active registers (R2 widths 48/14/12)
  logic [47:0] mbuf [3];
  logic [47:0] mact [3];

  function automatic logic [47:0] wmask(input int a);
    case (a)
      0: return 48'hFFFF_FFFF_FFFF;
      1: return 48'h3FFF;
      default: return 48'hFFF;
    endcase
  endfunction

  function automatic int nbytes(input int a);
    case (a)
      0: return 6;
      1: return 2;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  // Monitor: pops an expected item for every observation and compares
  initial begin
    forever begin
      @(obs_ev);
      begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (obs_val !== it.val) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.req, obs_val, it.val);
        end
      end
    end
  end

  task automatic expect_obs(input string req, input logic [47:0] exp, input logic [47:0] act);
    exp_t it;
    it.req = req;
    it.val = exp;
    exp_q.push_back(it);
    obs_val = act;
    ->obs_ev;
    #1;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic rb);
    tb_bit = b;
    wait_clk(HALF);
    rb = sdio;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b);
    logic rb;
    tb_oe = 1'b1;
    for (int i = 7; i >= 0; i--) sbit(b[i], rb);
  endtask

  task automatic rbyte(output logic [7:0] b);
    logic rb;
    tb_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sbit(1'b0, rb);
      b[i] = rb;
    end
  endtask

  task automatic sel();
    tb_oe = 1'b1; tb_bit = 1'b0;
    cs_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic desel();
    wait_clk(6);
    cs_n = 1'b1;
    tb_oe = 1'b1; tb_bit = 1'b0;
    wait_clk(8);
  endtask

  // Write body (instruction plus data), updates the bench model
  task automatic wr_body(input logic [7:0] instr, input logic [47:0] v);
    int a = int'(instr[3:0]);
    int n = nbytes(a);
    wbyte(instr);
    for (int k = n - 1; k >= 0; k--) wbyte(v[k*8 +: 8]);
    if (a < 3) mbuf[a] = v & wmask(a);
  endtask

  task automatic rd_body(input logic [7:0] instr, output logic [47:0] v);
    int n = nbytes(int'(instr[3:0]));
    logic [7:0] b;
    v = '0;
    wbyte(instr);
    for (int k = 0; k < n; k++) begin
      rbyte(b);
      v = {v[39:0], b};
    end
    tb_oe = 1'b1;
  endtask

  task automatic wr_reg(input logic [7:0] instr, input logic [47:0] v);
    sel(); wr_body(instr, v); desel();
  endtask

  task automatic rd_check(input string req, input logic [7:0] instr, input logic [47:0] exp);
    logic [47:0] v;
    sel(); rd_body(instr, v); desel();
    expect_obs(req, exp, v);
  endtask

  task automatic pulse_upd();
    upd = 1'b1; wait_clk(6);
    upd = 1'b0; wait_clk(6);
    for (int i = 0; i < 3; i++) mact[i] = mbuf[i];
  endtask

  task automatic check_active(input string req);
    expect_obs({req, " freq"},  mact[0], {freq_word});
    expect_obs({req, " phase"}, mact[1], {34'd0, phase_word});
    expect_obs({req, " amp"},   mact[2], {36'd0, amp_word});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin mbuf[i] = '0; mact[i] = '0; end
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R10: reset state
    check_active("R10 reset");
    expect_obs("R10 pin released", 48'd0, {47'd0, sdio});

    // R3/R2: writes go to buffer only; phase top bits dropped
    wr_reg(8'h00, 48'h1234_5678_9ABC);
    wr_reg(8'h01, 48'hEABC);
    wr_reg(8'h02, 48'hFF5A);
    check_active("R3 no update yet");

    // R5/R2: reads return buffer contents MSB first
    rd_check("R5 read freq",  8'h80, 48'h1234_5678_9ABC);
    rd_check("R2 read phase", 8'h81, 48'h2ABC);
    rd_check("R2 read amp",   8'h82, 48'h0F5A);

    // R4: update copies buffer to active
    pulse_upd();
    check_active("R4 after update");

    // R4: held level gives one copy only
    upd = 1'b1; wait_clk(10);
    wr_reg(8'h02, 48'h0123);
    expect_obs("R4 level held amp", 48'hF5A, {36'd0, amp_word});
    upd = 1'b0; wait_clk(6);
    pulse_upd();
    expect_obs("R4 new edge amp", 48'h123, {36'd0, amp_word});

    // R6: back-to-back transactions in one selection
    begin
      logic [47:0] v;
      sel();
      wr_body(8'h01, 48'h1111);
      wr_body(8'h02, 48'h0777);
      rd_body(8'h80, v);
      desel();
      expect_obs("R6 chained read freq", 48'h1234_5678_9ABC, v);
    end
    pulse_upd();
    check_active("R6 chained writes");

    // R1: instruction bits 6:4 ignored
    wr_reg(8'h72, 48'h0ABC);
    rd_check("R1 read with junk bits", 8'hF2, 48'h0ABC);

    // R2: unmapped address takes one byte, discarded, reads zero
    begin
      logic [47:0] v;
      sel();
      wbyte(8'h09); wbyte(8'hFF);
      wr_body(8'h01, 48'h0055);
      desel();
    end
    rd_check("R2 unmapped read", 8'h89, 48'h00);
    rd_check("R2 after unmapped write", 8'h81, 48'h0055);

    // R8: sclk ignored while deselected
    tb_bit = 1'b1;
    for (int i = 0; i < 5; i++) begin
      wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    tb_bit = 1'b0;
    wr_reg(8'h01, 48'h2222);
    rd_check("R8 sclk ignored", 8'h81, 48'h2222);

    // R7: port reset drops partial byte, keeps completed ones
    begin
      logic rb;
      sel();
      wbyte(8'h02);
      wbyte(8'h05);
      for (int i = 0; i < 4; i++) sbit(1'b1, rb);
      io_rst = 1'b1; wait_clk(6);
      io_rst = 1'b0; wait_clk(6);
      wr_body(8'h01, 48'h3344);
      desel();
      mbuf[2] = 48'h5BC;
    end
    rd_check("R7 amp partial kept", 8'h82, 48'h05BC);
    rd_check("R7 realigned phase",  8'h81, 48'h3344);

    // R9: update mid-write moves only complete bytes
    pulse_upd();
    sel();
    wbyte(8'h00);
    wbyte(8'hA1); wbyte(8'hB2); wbyte(8'hC3);
    upd = 1'b1; wait_clk(6); upd = 1'b0; wait_clk(6);
    expect_obs("R9 partial transfer", 48'hA1B2_C378_9ABC, freq_word);
    wbyte(8'hD4); wbyte(8'hE5); wbyte(8'hF6);
    desel();
    expect_obs("R3 freq held", 48'hA1B2_C378_9ABC, freq_word);
    mbuf[0] = 48'hA1B2_C3D4_E5F6;
    pulse_upd();
    check_active("R9 full transfer");

    // R8: raising chip select releases a driven pin
    wr_reg(8'h02, 48'h0FFF);
    begin
      logic [7:0] b;
      sel();
      wbyte(8'h82);
      rbyte(b);
      expect_obs("R5 first read byte", 48'h0F, {40'd0, b});
      expect_obs("R5 pin driven high", 48'd1, {47'd0, sdio});
      cs_n = 1'b1;
      tb_oe = 1'b1; tb_bit = 1'b0;
      wait_clk(10);
      expect_obs("R8 pin released", 48'd0, {47'd0, sdio});
      wait_clk(8);
    end
    rd_check("R8 realigned read", 8'h82, 48'h0FFF);

    wait_clk(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule